// File: doc/BRIEF.md
# Change-Gated Capture Register

This block watches a vector of single-bit signals, registers each one, and flags every bit whose current value differs from the value it held at the previous clock edge. The flag comes from comparing each monitor flop's input with its output, so it is exactly one clock cycle wide. The per-bit flags are reduced to one load enable. A parameter chooses the reduction: every watched bit must flip in the same cycle, or any single bit flipping is enough.

A data register captures `data_i` on a clock edge where the enable is high and holds its contents otherwise. The enable is also driven out so that surrounding logic can observe it. An active-low asynchronous reset clears the monitor flops and the data register. After each reset release, the enable is suppressed until the monitor flops have taken one real sample. This stops the values forced by reset from being reported as a change.

Top module: `change_gated_reg`

## Requirements
- R1: While `rst_ni` is 0, `data_o` is 0 and `en_o` is 0, independent of `mon_i` and `data_i`.
- R2: In the first clock cycle after `rst_ni` returns to 1, `en_o` is 0 and `data_o` is not loaded, even when `mon_i` differs from the cleared monitor state.
- R3: A bit counts as changed in a cycle only when its `mon_i` value differs from the value sampled at the previous clock edge. A change that is held for a further cycle gives no further indication.
- R4: With `MODE` = `CMB_ALL` (encoding 1), `en_o` is 1 exactly when every bit of `mon_i` has changed in the current cycle.
- R5: With `MODE` = `CMB_ANY` (encoding 0), `en_o` is 1 exactly when at least one bit of `mon_i` has changed in the current cycle.
- R6: On a clock edge where `en_o` is 1, `data_o` takes the value of `data_i`.
- R7: On a clock edge where `en_o` is 0, `data_o` keeps its value and `data_i` has no effect.
- R8: Asserting `rst_ni` low in the middle of operation clears `data_o` at once, and R2 applies again at the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mon_i | input | N_MON | Watched signal vector |
| data_i | input | DATA_W | Value captured when the enable is high |
| data_o | output | DATA_W | Captured register contents |
| en_o | output | 1 | Combined change enable for the current cycle |

## Verification
A broken monitor flop or XOR shows up as a wrong `en_o` in the same cycle. It also corrupts `data_o` one edge later, because the data register either loads a value it should have held or misses a load. The bench drives two copies of the block, one per combine mode, with identical stimulus. The patterns separate the modes: all bits flipping, some bits flipping, and no bits flipping. A fault in the reset priming shows up as an enable in the first cycle after release, which the bench checks after both the initial reset and a reset asserted mid-run.

// File: rtl/cgr_pkg.sv
package cgr_pkg;
  typedef enum logic {
    CMB_ANY = 1'b0,
    CMB_ALL = 1'b1
  } cmb_mode_e;
endpackage

// File: rtl/cgr_edge_mon.sv
module cgr_edge_mon #(
  parameter int N_MON = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MON-1:0] mon_i,
  output logic [N_MON-1:0] chg_o,
  output logic             primed_o
);
  logic [N_MON-1:0] mon_q;

  for (genvar b = 0; b < N_MON; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mon_q[b] <= 1'b0;
      else         mon_q[b] <= mon_i[b];
    end
    // D xor Q: one cycle wide per change
    assign chg_o[b] = mon_i[b] ^ mon_q[b];
  end

  // first sample after reset is not a real history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_o <= 1'b0;
    else         primed_o <= 1'b1;
  end
endmodule

// File: rtl/cgr_combine.sv
module cgr_combine
  import cgr_pkg::*;
#(
  parameter int        N_MON = 4,
  parameter cmb_mode_e MODE  = CMB_ALL
) (
  input  logic [N_MON-1:0] chg_i,
  input  logic             primed_i,
  output logic             en_o
);
  logic hit;

  if (MODE == CMB_ALL) begin : g_all
    assign hit = &chg_i;
  end else begin : g_any
    assign hit = |chg_i;
  end

  assign en_o = primed_i & hit;
endmodule

// File: rtl/cgr_hold_reg.sv
module cgr_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  // no final else: register holds when disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/change_gated_reg.sv
module change_gated_reg
  import cgr_pkg::*;
#(
  parameter int        N_MON  = 4,
  parameter int        DATA_W = 8,
  parameter cmb_mode_e MODE   = CMB_ALL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_MON-1:0]  mon_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              en_o
);
  logic [N_MON-1:0] chg;
  logic             primed;

  cgr_edge_mon #(.N_MON(N_MON)) u_mon (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mon_i    (mon_i),
    .chg_o    (chg),
    .primed_o (primed)
  );

  cgr_combine #(.N_MON(N_MON), .MODE(MODE)) u_cmb (
    .chg_i    (chg),
    .primed_i (primed),
    .en_o     (en_o)
  );

  cgr_hold_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_o),
    .d_i    (data_i),
    .q_o    (data_o)
  );
endmodule

// File: rtl/change_gated_reg_chk.sv
module change_gated_reg_chk
  import cgr_pkg::*;
#(
  parameter int        N_MON  = 4,
  parameter int        DATA_W = 8,
  parameter cmb_mode_e MODE   = CMB_ALL
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_MON-1:0]  mon_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              en_o
);
  AST_RST_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> (data_o == '0 && !en_o)); // R1

  AST_FIRST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(rst_ni) |-> !en_o); // R2

  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni) en_o |=> ($stable(mon_i) -> !en_o)); // R3

  if (MODE == CMB_ALL) begin : g_all
    AST_ALL_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni) en_o |-> ((mon_i ^ $past(mon_i)) == '1)); // R4
  end else begin : g_any
    AST_ANY_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni) en_o |-> (mon_i != $past(mon_i))); // R5
  end

  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni) en_o |=> (data_o == $past(data_i))); // R6

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !en_o |=> $stable(data_o)); // R7
endmodule

bind change_gated_reg change_gated_reg_chk #(
  .N_MON(N_MON), .DATA_W(DATA_W), .MODE(MODE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mon_i(mon_i),
  .data_i(data_i), .data_o(data_o), .en_o(en_o)
);

// File: tb/tb_change_gated_reg.sv
module tb_change_gated_reg;
  import cgr_pkg::*;

  localparam int N = 4;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic [N-1:0] mon_i = '0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] dout_all, dout_any;
  logic         en_all, en_any;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i; // 125 MHz

  change_gated_reg #(.N_MON(N), .DATA_W(W), .MODE(CMB_ALL)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mon_i(mon_i), .data_i(data_i),
    .data_o(dout_all), .en_o(en_all)
  );

  change_gated_reg #(.N_MON(N), .DATA_W(W), .MODE(CMB_ANY)) dut_any (
    .clk_i(clk_i), .rst_ni(rst_ni), .mon_i(mon_i), .data_i(data_i),
    .data_o(dout_any), .en_o(en_any)
  );

  typedef struct {
    logic         en_a;
    logic         en_o;
    logic [W-1:0] d_a;
    logic [W-1:0] d_o;
    string        tag;
  } item_t;

  item_t q[$];

  // reference state
  logic [N-1:0] m_prev;
  logic         m_primed;
  logic [W-1:0] m_da, m_do;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset(input logic [N-1:0] m);
    m_prev = m; m_primed = 1'b1; m_da = '0; m_do = '0;
  endtask

  task automatic drive(input logic [N-1:0] m, input logic [W-1:0] d, input string tag);
    item_t it;
    logic [N-1:0] c;
    @(negedge clk_i);
    mon_i = m; data_i = d;
    c = m ^ m_prev;
    it.en_a = m_primed && (c == '1);
    it.en_o = m_primed && (c != '0);
    it.d_a  = it.en_a ? d : m_da;
    it.d_o  = it.en_o ? d : m_do;
    it.tag  = tag;
    m_prev = m; m_da = it.d_a; m_do = it.d_o;
    q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      item_t it;
      @(negedge clk_i);
      #2;
      if (q.size() != 0) begin
        it = q.pop_front();
        chk({it.tag, " R4 en all-mode"}, W'(en_all), W'(it.en_a));
        chk({it.tag, " R5 en any-mode"}, W'(en_any), W'(it.en_o));
        @(posedge clk_i);
        #1;
        chk({it.tag, it.en_a ? " R6 load all-mode" : " R7 hold all-mode"}, dout_all, it.d_a);
        chk({it.tag, it.en_o ? " R6 load any-mode" : " R7 hold any-mode"}, dout_any, it.d_o);
      end
    end
  end

  task automatic release_and_check(input string tag);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #2;
    chk({tag, " first cycle en all"}, W'(en_all), '0);
    chk({tag, " first cycle en any"}, W'(en_any), '0);
    @(posedge clk_i);
    #1;
    chk({tag, " first cycle no load all"}, dout_all, '0);
    chk({tag, " first cycle no load any"}, dout_any, '0);
    model_reset(mon_i);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    mon_i = 4'hF; data_i = 8'hAA;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 data in reset", dout_all, '0);
    chk("R1 en in reset", W'(en_any | en_all), '0);
    release_and_check("R2");

    drive(4'hF, 8'h11, "R7 no change");
    drive(4'h0, 8'h22, "all flip");
    drive(4'h0, 8'h33, "R3 held value");
    drive(4'h1, 8'h44, "single flip");
    drive(4'hE, 8'h55, "all flip");
    drive(4'hC, 8'h66, "partial flip");
    drive(4'h3, 8'h77, "all flip");
    drive(4'h3, 8'h88, "R3 held value");
    for (int i = 0; i < 24; i++)
      drive(N'(i * 5 + (i >> 2)), W'(i * 29 + 3), "sweep");

    // mid-run reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R8 data cleared all", dout_all, '0);
    chk("R8 data cleared any", dout_any, '0);
    mon_i = 4'h5; data_i = 8'hC3;
    repeat (2) @(posedge clk_i);
    release_and_check("R8");
    drive(4'hA, 8'h5A, "R8 after rearm");
    drive(4'hB, 8'h6B, "R8 after rearm");
    drive(4'hB, 8'h7C, "R3 held value");
    repeat (3) @(posedge clk_i);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100us;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule